// File: doc/BRIEF.md
# Auto-Reload Decrementer Timer

A 32-bit down-counter that advances on a time-base tick enable and tells the processor core when a programmed interval has elapsed. Software programs it through a single register write port that selects one of four registers: the count, a reload value, a control word and a status word. When the interval ends, a sticky status flag is set. The interrupt output is high while that flag and an interrupt-enable control bit are both set. With auto-reload enabled, the counter restarts from the reload register at expiry and keeps counting. This gives a periodic tick with no software write in the loop.

A mode input selects how expiry is detected. In zero-trigger mode the count stops at zero and cannot go negative. In underflow mode the count runs freely through zero, and a software write can also count as an event. The zero-trigger behaviour is built as a two-state machine. In `ST_HOLD` the count sits at zero and does not count. In `ST_COUNT` the count is live. A count write always moves the machine to `ST_COUNT`. In zero-trigger mode, a tick that expires the count with auto-reload off moves it to `ST_HOLD`. In underflow mode, any tick moves it to `ST_COUNT`. Reset places the machine in `ST_HOLD`.

Register select codes on `wr_sel`: 0 = count, 1 = reload, 2 = control, 3 = status.

Top module: `autoreload_decr`

## Requirements
- R1: Reset clears the count, reload, control and status registers, and `irq_o` is low.
- R2: A write with select 0 loads the count from `wr_data` on the next clock edge. It takes priority over a tick in the same cycle.
- R3: In any cycle with `tick_en` high and no count write, the count falls by exactly one, except at an expiry. With `tick_en` low it is unchanged.
- R4: In zero-trigger mode (`mode_zero`=1), a tick that takes the count from 1 to 0 sets status bit 27. With auto-reload off (control bit 22 = 0), later ticks leave the count at zero and raise no new expiry.
- R5: In zero-trigger mode, writing zero to the count makes the next tick an expiry that sets status bit 27, and the count stays zero.
- R6: In underflow mode (`mode_zero`=0), a tick while the count is zero wraps it to 0xFFFFFFFF and sets status bit 27.
- R7: In underflow mode, a count write whose bit 31 is 1 while the current count's bit 31 is 0 sets status bit 27 at once. If the current bit 31 is already 1, the same write sets nothing.
- R8: With control bit 22 set, an expiry loads the count from the reload register, and the count keeps decrementing on later ticks.
- R9: A write with select 3 clears status bit 27 when data bit 27 is 1, and leaves it unchanged when data bit 27 is 0. Status bit 27 stays set until it is cleared this way.
- R10: `irq_o` equals status bit 27 AND control bit 26, and follows a change of either register.
- R11: When an expiry and a status clear fall in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base tick; one decrement per high cycle |
| mode_zero | input | 1 | 1 = zero-trigger mode, 0 = underflow mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 reload, 2 control, 3 status |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Current count |
| reload_o | output | 32 | Reload register |
| ctrl_o | output | 32 | Control register (bit 26 interrupt enable, bit 22 auto-reload) |
| status_o | output | 32 | Status register (bit 27 expiry flag, other bits zero) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the per-cycle rules: a count write lands on the next edge, a tick decrements a live count, a held zero stays zero, a status flag set by expiry stays set until written one, a written one clears the flag on a tickless cycle, and the interrupt gate holds. Only the bench scenarios can show that expiry fires at the right point in a countdown and that the reload value comes back. They also cover the write-triggered event of underflow mode, which depends on the previous value's sign bit, the wrap to all ones, and the set-over-clear ordering.

// File: rtl/decr_pkg.sv
package decr_pkg;
    localparam int DW          = 32;
    localparam int STAT_DIS    = 27;
    localparam int CTRL_IE     = 26;
    localparam int CTRL_ARE    = 22;
    localparam int SIGN_BIT    = DW - 1;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STAT   = 2'd3
    } sel_e;

    typedef enum logic {
        ST_HOLD  = 1'b0,
        ST_COUNT = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/decr_core.sv
module decr_core
    import decr_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         mode_zero,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic         are,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count_o,
    output logic         expire_o
);
    localparam int MSB = W - 1;
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    cnt_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    // Next-state and next-count logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (ld_en) begin
            cnt_d   = ld_val;
            state_d = ST_COUNT;
        end else if (tick_en) begin
            if (mode_zero) begin
                unique case (state_q)
                    ST_HOLD: begin
                        cnt_d = cnt_q;
                    end
                    ST_COUNT: begin
                        if (cnt_q <= ONE) begin
                            cnt_d   = are ? reload_val : '0;
                            state_d = are ? ST_COUNT : ST_HOLD;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                    default: state_d = ST_HOLD;
                endcase
            end else begin
                state_d = ST_COUNT;
                if (cnt_q == '0) begin
                    cnt_d = are ? reload_val : ALL1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output decode: expiry events.
    always_comb begin
        expire_o = 1'b0;
        if (ld_en) begin
            expire_o = !mode_zero && ld_val[MSB] && !cnt_q[MSB];
        end else if (tick_en) begin
            if (mode_zero) begin
                expire_o = (state_q == ST_COUNT) && (cnt_q <= ONE);
            end else begin
                expire_o = (cnt_q == '0);
            end
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/decr_regs.sv
module decr_regs
    import decr_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         expire,
    output logic [W-1:0] reload_o,
    output logic [W-1:0] ctrl_o,
    output logic         stat_dis_o
);
    logic [W-1:0] reload_q, ctrl_q;
    logic         dis_q;
    logic         clr;

    assign clr = wr_en && (sel_e'(wr_sel) == SEL_STAT) && wr_data[STAT_DIS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
            dis_q    <= 1'b0;
        end else begin
            if (wr_en && sel_e'(wr_sel) == SEL_RELOAD) reload_q <= wr_data;
            if (wr_en && sel_e'(wr_sel) == SEL_CTRL)   ctrl_q   <= wr_data;
            // A new expiry wins over a clear in the same cycle.
            dis_q <= (dis_q && !clr) || expire;
        end
    end

    assign reload_o   = reload_q;
    assign ctrl_o     = ctrl_q;
    assign stat_dis_o = dis_q;
endmodule

// File: rtl/autoreload_decr.sv
module autoreload_decr
    import decr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        mode_zero,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] count_o,
    output logic [31:0] reload_o,
    output logic [31:0] ctrl_o,
    output logic [31:0] status_o,
    output logic        irq_o
);
    logic expire;
    logic dis;
    logic ld_en;

    assign ld_en = wr_en && (sel_e'(wr_sel) == SEL_COUNT);

    decr_core #(.W(DW)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .mode_zero  (mode_zero),
        .ld_en      (ld_en),
        .ld_val     (wr_data),
        .are        (ctrl_o[CTRL_ARE]),
        .reload_val (reload_o),
        .count_o    (count_o),
        .expire_o   (expire)
    );

    decr_regs #(.W(DW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .expire     (expire),
        .reload_o   (reload_o),
        .ctrl_o     (ctrl_o),
        .stat_dis_o (dis)
    );

    assign status_o = DW'(dis) << STAT_DIS;
    assign irq_o    = dis && ctrl_o[CTRL_IE];
endmodule

// File: rtl/decr_checker.sv
module decr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        mode_zero,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] count_o,
    input logic        ie_bit,
    input logic        are_bit,
    input logic        dis_bit,
    input logic        irq_o
);
    logic cnt_wr, stat_clr;
    assign cnt_wr   = wr_en && (wr_sel == 2'd0);
    assign stat_clr = wr_en && (wr_sel == 2'd3) && wr_data[27];

    a_r2_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> count_o == $past(wr_data));

    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr && mode_zero && count_o > 32'd1)
        |=> count_o == $past(count_o) - 32'd1);

    a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_wr) |=> $stable(count_o));

    a_r4_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_zero && count_o == 32'd0 && !cnt_wr && !are_bit) |=> count_o == 32'd0);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_bit && !stat_clr) |=> dis_bit);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !tick_en) |=> !dis_bit);

    a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (dis_bit && ie_bit));
endmodule

bind autoreload_decr decr_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .mode_zero (mode_zero),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .count_o   (count_o),
    .ie_bit    (ctrl_o[26]),
    .are_bit   (ctrl_o[22]),
    .dis_bit   (status_o[27]),
    .irq_o     (irq_o)
);

// File: tb/autoreload_decr_tb_top.sv
module autoreload_decr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        mode_zero = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] count_o, reload_o, ctrl_o, status_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;

    localparam logic [1:0]  S_CNT = 2'd0, S_RLD = 2'd1, S_CTL = 2'd2, S_STA = 2'd3;
    localparam logic [31:0] DIS = 32'h0800_0000;
    localparam logic [31:0] IE  = 32'h0400_0000;
    localparam logic [31:0] ARE = 32'h0040_0000;

    always #2 clk = ~clk;

    autoreload_decr dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_zero(mode_zero),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .count_o(count_o), .reload_o(reload_o), .ctrl_o(ctrl_o),
        .status_o(status_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock with the given inputs; returns at the next falling edge.
    task automatic step(input logic w, input logic [1:0] s, input logic [31:0] d, input logic t);
        @(negedge clk);
        wr_en = w; wr_sel = s; wr_data = d; tick_en = t;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, S_CNT, '0, 1'b1);
    endtask

    task automatic t_reset;
        chk("R1 count", count_o, '0);
        chk("R1 reload", reload_o, '0);
        chk("R1 ctrl", ctrl_o, '0);
        chk("R1 status", status_o, '0);
        chk("R1 irq", {31'b0, irq_o}, 32'd0);
    endtask

    task automatic t_load_and_count;
        step(1'b1, S_CNT, 32'd5, 1'b1);
        chk("R2 write beats tick", count_o, 32'd5);
        step(1'b0, S_CNT, '0, 1'b0);
        step(1'b0, S_CNT, '0, 1'b0);
        chk("R3 no tick no change", count_o, 32'd5);
        ticks(3);
        chk("R3 three ticks", count_o, 32'd2);
    endtask

    task automatic t_zero_expire;
        ticks(1);
        chk("R3 reach one", count_o, 32'd1);
        chk("R4 not yet expired", status_o, '0);
        ticks(1);
        chk("R4 count zero", count_o, '0);
        chk("R4 status set", status_o, DIS);
        step(1'b1, S_STA, DIS, 1'b0);
        ticks(3);
        chk("R4 held at zero", count_o, '0);
        chk("R4 no new expiry", status_o, '0);
    endtask

    task automatic t_zero_write;
        step(1'b1, S_CNT, 32'd0, 1'b0);
        chk("R5 no event on write", status_o, '0);
        ticks(1);
        chk("R5 expiry on next tick", status_o, DIS);
        chk("R5 count stays zero", count_o, '0);
    endtask

    task automatic t_w1c;
        step(1'b1, S_STA, 32'd0, 1'b0);
        chk("R9 zero write keeps", status_o, DIS);
        step(1'b1, S_STA, 32'hF7FF_FFFF, 1'b0);
        chk("R9 other ones keep", status_o, DIS);
        step(1'b1, S_STA, DIS, 1'b0);
        chk("R9 one clears", status_o, '0);
    endtask

    task automatic t_irq;
        step(1'b1, S_CNT, 32'd0, 1'b0);
        ticks(1);
        chk("R10 irq off without enable", {31'b0, irq_o}, 32'd0);
        step(1'b1, S_CTL, IE, 1'b0);
        chk("R10 irq on enable", {31'b0, irq_o}, 32'd1);
        step(1'b1, S_STA, DIS, 1'b0);
        chk("R10 irq off after clear", {31'b0, irq_o}, 32'd0);
    endtask

    task automatic t_reload;
        step(1'b1, S_CTL, IE | ARE, 1'b0);
        step(1'b1, S_RLD, 32'd7, 1'b0);
        chk("R8 reload reg", reload_o, 32'd7);
        step(1'b1, S_CNT, 32'd1, 1'b0);
        ticks(1);
        chk("R8 reloaded", count_o, 32'd7);
        chk("R8 status set", status_o, DIS);
        ticks(1);
        chk("R8 keeps counting", count_o, 32'd6);
        step(1'b1, S_STA, DIS, 1'b0);
    endtask

    task automatic t_set_wins;
        step(1'b1, S_CTL, 32'd0, 1'b0);
        step(1'b1, S_CNT, 32'd1, 1'b0);
        step(1'b1, S_STA, DIS, 1'b1);
        chk("R11 set over clear", status_o, DIS);
        chk("R11 count", count_o, '0);
        step(1'b1, S_STA, DIS, 1'b0);
    endtask

    task automatic t_underflow;
        @(negedge clk);
        mode_zero = 1'b0;
        step(1'b1, S_CNT, 32'd0, 1'b0);
        chk("R7 positive write no event", status_o, '0);
        ticks(1);
        chk("R6 wrap", count_o, 32'hFFFF_FFFF);
        chk("R6 status set", status_o, DIS);
        step(1'b1, S_STA, DIS, 1'b0);
        step(1'b1, S_CNT, 32'h8000_0005, 1'b0);
        chk("R7 sign already set no event", status_o, '0);
        step(1'b1, S_CNT, 32'd3, 1'b0);
        chk("R7 positive load", status_o, '0);
        step(1'b1, S_CNT, 32'h8000_0000, 1'b0);
        chk("R7 sign rise event", status_o, DIS);
        chk("R7 count loaded", count_o, 32'h8000_0000);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_and_count();
        t_zero_expire();
        t_zero_write();
        t_w1c();
        t_irq();
        t_reload();
        t_set_wins();
        t_underflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule